// File: doc/BRIEF.md
# Dual-Bundle Instruction Dispersal Unit

This unit sits between an instruction fetch queue and the execution units of a statically scheduled wide-issue core. Each incoming word is a 128-bit bundle that holds three 41-bit operations and a 5-bit template. The template states which kind of unit each slot needs: memory/address, integer, floating-point or branch. It also states where issue groups end. The unit keeps up to two bundles in an issue window. In each cycle it walks the pending slots in program order, from the older bundle into the newer one, and builds the current issue group. It routes each operation of that group to an issue port of the matching unit kind. It does not check for dependences or hazards inside a group. The compiler is trusted to have placed independent operations between group boundaries.

There are `PPT` ports per unit kind. A group with more operations of one kind than there are ports of that kind is split in slot order. A group issues as a whole or not at all. The group's operations stay on their ports until every port that shows a valid operation also signals ready. When every slot of a bundle has gone, the bundle leaves the window and the fetch side may send a new one. A bundle whose template code is not a legal pattern is accepted and discarded, and the unit raises a one-cycle flag for it.

Top module: `bundle_disperse`

## Requirements
- R1: After synchronous reset, all port valids are low, `bnd_ready_o` is high and `bad_tpl_o` is low.
- R2: The template is bits 4:0 of a bundle. Operation slot 0 is bits 45:5, slot 1 is bits 86:46 and slot 2 is bits 127:87. Unit kinds are coded memory=0, integer=1, floating-point=2, branch=3. The k-th operation of kind t within one issue cycle appears on port t*PPT+k with its 41 bits unchanged.
- R3: Template bits 4:1 select a pattern, written as kinds of slot 0, slot 1, slot 2: 0 MII, 1 MII with a boundary after slot 1, 2 MMI, 3 MMI with a boundary after slot 0, 4 MFI, 5 MMF, 6 MIB, 7 MBB, 8 BBB, 9 MMB, 10 MFB. Template bit 0 places a boundary after slot 2.
- R4: A bundle with pattern code 11 to 15 is accepted, none of its operations ever issue, and `bad_tpl_o` is high for exactly the one cycle after its handshake.
- R5: An issue group ends at the first group boundary. Operations after the boundary issue in a later cycle, and groups issue in program order.
- R6: When the older bundle has no boundary after slot 2 and the newer bundle is already in the window, one group spans both bundles and its operations issue in the same cycle.
- R7: A group is consumed only in a cycle in which every port that shows a valid operation has its ready high. Until then each such port keeps its valid high and its payload unchanged.
- R8: When a group needs more than PPT ports of one kind, it is split in slot order at the operation that would exceed the count. The remainder issues in the next cycle, starting again from port index 0 of each kind.
- R9: The window holds two bundles. `bnd_ready_o` is low while two are held. A bundle whose slots have all issued frees its place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bnd_valid_i | input | 1 | Incoming bundle valid |
| bnd_data_i | input | 128 | Incoming bundle (template and three slots) |
| bnd_ready_o | output | 1 | Window can accept a bundle |
| port_ready_i | input | 4*PPT | Per issue port ready, port t*PPT+k |
| port_valid_o | output | 4*PPT | Per issue port operation valid |
| port_op_o | output | 4*PPT x 41 | Per issue port operation payload |
| bad_tpl_o | output | 1 | One-cycle flag for a discarded illegal-template bundle |

## Verification
The case that needs care is when a group boundary from the template and a split from port capacity or the window edge land on the same issue cycle. For R6 the bench holds every port ready low while two bundles load, so the group crossing the bundle edge must appear as six valid ports at once and then retire in a single cycle. The scoreboard tags every expected operation with a group number. At each consumed cycle it checks that the retired operations form exactly one whole group, and the oldest one still outstanding. A pattern with three branch operations forces a capacity split, and the internal-boundary patterns force template splits. Port readiness is toggled pseudo-randomly during a long stream, so stalls fall on both kinds of split.

// File: rtl/bdisp_pkg.sv
package bdisp_pkg;

    localparam int OP_W     = 41;
    localparam int BUNDLE_W = 128;
    localparam int TPL_W    = 5;
    localparam int SLOTS    = 3;
    localparam int KINDS    = 4;
    localparam int WIN      = 2;

    typedef enum logic [1:0] {
        U_MEM = 2'd0,
        U_INT = 2'd1,
        U_FP  = 2'd2,
        U_BR  = 2'd3
    } unit_e;

    // kind[s] is the unit kind of slot s; stop[s] ends a group after slot s
    typedef struct packed {
        logic                    legal;
        logic [SLOTS-1:0]        stop;
        logic [SLOTS-1:0][1:0]   kind;
    } tpl_info_t;

    function automatic tpl_info_t tpl_decode(input logic [TPL_W-1:0] t);
        tpl_info_t r;
        r.legal = 1'b1;
        r.stop  = {t[0], 2'b00};
        r.kind  = '0;
        case (t[4:1])
            4'd0:  r.kind = {U_INT, U_INT, U_MEM};
            4'd1:  begin r.kind = {U_INT, U_INT, U_MEM}; r.stop[1] = 1'b1; end
            4'd2:  r.kind = {U_INT, U_MEM, U_MEM};
            4'd3:  begin r.kind = {U_INT, U_MEM, U_MEM}; r.stop[0] = 1'b1; end
            4'd4:  r.kind = {U_INT, U_FP,  U_MEM};
            4'd5:  r.kind = {U_FP,  U_MEM, U_MEM};
            4'd6:  r.kind = {U_BR,  U_INT, U_MEM};
            4'd7:  r.kind = {U_BR,  U_BR,  U_MEM};
            4'd8:  r.kind = {U_BR,  U_BR,  U_BR};
            4'd9:  r.kind = {U_BR,  U_MEM, U_MEM};
            4'd10: r.kind = {U_BR,  U_FP,  U_MEM};
            default: begin
                r.legal = 1'b0;
                r.stop  = '0;
            end
        endcase
        return r;
    endfunction

    function automatic logic [OP_W-1:0] slot_op(input logic [BUNDLE_W-1:0] b,
                                                input int s);
        return b[TPL_W + s*OP_W +: OP_W];
    endfunction

endpackage

// File: rtl/bdisp_window.sv
module bdisp_window
    import bdisp_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              in_valid,
    input  logic [BUNDLE_W-1:0]               in_data,
    output logic                              in_ready,
    input  logic [WIN-1:0][SLOTS-1:0]         consume,
    output logic [WIN-1:0]                    ent_vld,
    output logic [WIN-1:0][BUNDLE_W-1:0]      ent_data,
    output logic [WIN-1:0][SLOTS-1:0]         ent_pend,
    output logic                              bad_o
);

    logic [WIN-1:0]                 vld_q, vld_n;
    logic [WIN-1:0][BUNDLE_W-1:0]   dat_q, dat_n;
    logic [WIN-1:0][SLOTS-1:0]      pend_q, pend_n;
    logic [SLOTS-1:0]               left0, left1;
    logic                           keep0, keep1, acc, good, bad_q;
    tpl_info_t                      in_inf;

    assign in_inf   = tpl_decode(in_data[TPL_W-1:0]);
    assign in_ready = !vld_q[1];
    assign acc      = in_valid && in_ready;
    assign good     = acc && in_inf.legal;

    always_comb begin
        left0 = pend_q[0] & ~consume[0];
        left1 = pend_q[1] & ~consume[1];
        keep0 = vld_q[0] && (|left0);
        keep1 = vld_q[1] && (|left1);
        vld_n  = '0;
        dat_n  = dat_q;
        pend_n = '0;
        if (keep0) begin
            vld_n[0] = 1'b1; dat_n[0] = dat_q[0]; pend_n[0] = left0;
            if (keep1) begin
                vld_n[1] = 1'b1; dat_n[1] = dat_q[1]; pend_n[1] = left1;
            end else if (good) begin
                vld_n[1] = 1'b1; dat_n[1] = in_data; pend_n[1] = '1;
            end
        end else if (keep1) begin
            vld_n[0] = 1'b1; dat_n[0] = dat_q[1]; pend_n[0] = left1;
            if (good) begin
                vld_n[1] = 1'b1; dat_n[1] = in_data; pend_n[1] = '1;
            end
        end else if (good) begin
            vld_n[0] = 1'b1; dat_n[0] = in_data; pend_n[0] = '1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q  <= '0;
            pend_q <= '0;
            bad_q  <= 1'b0;
        end else begin
            vld_q  <= vld_n;
            pend_q <= pend_n;
            bad_q  <= acc && !in_inf.legal;
        end
        dat_q <= dat_n;
    end

    assign ent_vld  = vld_q;
    assign ent_data = dat_q;
    assign ent_pend = pend_q;
    assign bad_o    = bad_q;

endmodule

// File: rtl/bdisp_group_sel.sv
module bdisp_group_sel
    import bdisp_pkg::*;
#(
    parameter int PPT = 2,
    localparam int NP = KINDS * PPT,
    localparam int PW = (NP > 1) ? $clog2(NP) : 1,
    localparam int CW = $clog2(PPT + 1)
)(
    input  logic [WIN-1:0]                      ent_vld,
    input  logic [WIN-1:0][TPL_W-1:0]           ent_tpl,
    input  logic [WIN-1:0][SLOTS-1:0]           ent_pend,
    output logic [WIN-1:0][SLOTS-1:0]           take,
    output logic [WIN-1:0][SLOTS-1:0][PW-1:0]   slot_port
);

    tpl_info_t       info [WIN];
    logic [CW-1:0]   cnt  [KINDS];
    logic [1:0]      t;
    logic            go, any;

    generate
        for (genvar e = 0; e < WIN; e++) begin : g_dec
            assign info[e] = tpl_decode(ent_tpl[e]);
        end
    endgenerate

    // in-order walk: older bundle first, stop at boundary, window edge or port capacity
    always_comb begin
        take      = '0;
        slot_port = '0;
        go        = 1'b1;
        any       = 1'b0;
        t         = '0;
        for (int k = 0; k < KINDS; k++) cnt[k] = '0;
        for (int e = 0; e < WIN; e++) begin
            for (int s = 0; s < SLOTS; s++) begin
                if (go) begin
                    if (!ent_vld[e]) begin
                        go = 1'b0;
                    end else begin
                        if (ent_pend[e][s]) begin
                            t = info[e].kind[s];
                            if (cnt[t] == CW'(PPT)) begin
                                go = 1'b0;
                            end else begin
                                take[e][s]      = 1'b1;
                                slot_port[e][s] = PW'(int'(t) * PPT + int'(cnt[t]));
                                cnt[t]          = cnt[t] + CW'(1);
                                any             = 1'b1;
                            end
                        end
                        if (go && any && info[e].stop[s]) go = 1'b0;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/bdisp_port_xbar.sv
module bdisp_port_xbar
    import bdisp_pkg::*;
#(
    parameter int PPT = 2,
    localparam int NP = KINDS * PPT,
    localparam int PW = (NP > 1) ? $clog2(NP) : 1
)(
    input  logic [WIN-1:0][BUNDLE_W-1:0]        ent_data,
    input  logic [WIN-1:0][SLOTS-1:0]           take,
    input  logic [WIN-1:0][SLOTS-1:0][PW-1:0]   slot_port,
    input  logic [NP-1:0]                       port_ready,
    output logic [NP-1:0]                       port_valid,
    output logic [NP-1:0][OP_W-1:0]             port_op,
    output logic [WIN-1:0][SLOTS-1:0]           consume
);

    logic all_ok;

    always_comb begin
        port_valid = '0;
        port_op    = '0;
        for (int q = 0; q < NP; q++) begin
            for (int e = 0; e < WIN; e++) begin
                for (int s = 0; s < SLOTS; s++) begin
                    if (take[e][s] && slot_port[e][s] == PW'(q)) begin
                        port_valid[q] = 1'b1;
                        port_op[q]    = slot_op(ent_data[e], s);
                    end
                end
            end
        end
    end

    // whole group or nothing
    assign all_ok  = ((port_valid & ~port_ready) == '0);
    assign consume = all_ok ? take : '0;

endmodule

// File: rtl/bundle_disperse.sv
module bundle_disperse
    import bdisp_pkg::*;
#(
    parameter int PPT = 2,
    localparam int NP = KINDS * PPT,
    localparam int PW = (NP > 1) ? $clog2(NP) : 1
)(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      bnd_valid_i,
    input  logic [BUNDLE_W-1:0]       bnd_data_i,
    output logic                      bnd_ready_o,
    input  logic [NP-1:0]             port_ready_i,
    output logic [NP-1:0]             port_valid_o,
    output logic [NP-1:0][OP_W-1:0]   port_op_o,
    output logic                      bad_tpl_o
);

    logic [WIN-1:0]                      ent_vld;
    logic [WIN-1:0][BUNDLE_W-1:0]        ent_data;
    logic [WIN-1:0][TPL_W-1:0]           ent_tpl;
    logic [WIN-1:0][SLOTS-1:0]           ent_pend;
    logic [WIN-1:0][SLOTS-1:0]           take;
    logic [WIN-1:0][SLOTS-1:0]           consume;
    logic [WIN-1:0][SLOTS-1:0][PW-1:0]   slot_port;

    generate
        for (genvar e = 0; e < WIN; e++) begin : g_tpl
            assign ent_tpl[e] = ent_data[e][TPL_W-1:0];
        end
    endgenerate

    bdisp_window u_win (
        .clk      (clk),
        .rst      (rst),
        .in_valid (bnd_valid_i),
        .in_data  (bnd_data_i),
        .in_ready (bnd_ready_o),
        .consume  (consume),
        .ent_vld  (ent_vld),
        .ent_data (ent_data),
        .ent_pend (ent_pend),
        .bad_o    (bad_tpl_o)
    );

    bdisp_group_sel #(.PPT(PPT)) u_sel (
        .ent_vld   (ent_vld),
        .ent_tpl   (ent_tpl),
        .ent_pend  (ent_pend),
        .take      (take),
        .slot_port (slot_port)
    );

    bdisp_port_xbar #(.PPT(PPT)) u_xbar (
        .ent_data   (ent_data),
        .take       (take),
        .slot_port  (slot_port),
        .port_ready (port_ready_i),
        .port_valid (port_valid_o),
        .port_op    (port_op_o),
        .consume    (consume)
    );

endmodule

// File: rtl/bundle_disperse_chk.sv
module bundle_disperse_chk
    import bdisp_pkg::*;
#(
    parameter int PPT = 2,
    localparam int NP = KINDS * PPT
)(
    input logic                      clk,
    input logic                      rst,
    input logic                      bnd_valid_i,
    input logic [3:0]                pat_i,
    input logic                      bnd_ready_o,
    input logic [NP-1:0]             port_ready_i,
    input logic [NP-1:0]             port_valid_o,
    input logic [NP-1:0][OP_W-1:0]   port_op_o,
    input logic                      bad_tpl_o
);

    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (port_valid_o == '0 && bnd_ready_o && !bad_tpl_o));

    p_bad_follows_r4: assert property (@(posedge clk) disable iff (rst)
        (bnd_valid_i && bnd_ready_o && pat_i > 4'd10) |=> bad_tpl_o);

    p_bad_cause_r4: assert property (@(posedge clk) disable iff (rst)
        bad_tpl_o |-> $past(bnd_valid_i && bnd_ready_o && pat_i > 4'd10));

    p_full_busy_r9: assert property (@(posedge clk) disable iff (rst)
        !bnd_ready_o |-> (|port_valid_o));

    generate
        for (genvar q = 0; q < NP; q++) begin : g_hold
            p_stall_hold_r7: assert property (@(posedge clk) disable iff (rst)
                (port_valid_o[q] && !port_ready_i[q])
                    |=> (port_valid_o[q] && $stable(port_op_o[q])));
        end
    endgenerate

endmodule

bind bundle_disperse bundle_disperse_chk #(.PPT(PPT)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .bnd_valid_i  (bnd_valid_i),
    .pat_i        (bnd_data_i[4:1]),
    .bnd_ready_o  (bnd_ready_o),
    .port_ready_i (port_ready_i),
    .port_valid_o (port_valid_o),
    .port_op_o    (port_op_o),
    .bad_tpl_o    (bad_tpl_o)
);

// File: tb/bundle_disperse_bench.sv
`timescale 1ns/1ps
module bundle_disperse_bench;
    localparam int PPT = 2;
    localparam int NP  = 4 * PPT;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 bnd_valid = 1'b0;
    logic [127:0]         bnd_data  = '0;
    logic                 bnd_ready;
    logic [NP-1:0]        rdy = '1;
    logic [NP-1:0]        pv;
    logic [NP-1:0][40:0]  pop;
    logic                 bad;

    always #5 clk = ~clk;

    bundle_disperse #(.PPT(PPT)) u_bundle_disperse (
        .clk(clk), .rst(rst), .bnd_valid_i(bnd_valid), .bnd_data_i(bnd_data),
        .bnd_ready_o(bnd_ready), .port_ready_i(rdy), .port_valid_o(pv),
        .port_op_o(pop), .bad_tpl_o(bad)
    );

    typedef struct { int port; logic [40:0] op; int grp; } item_t;
    item_t sb[$];

    int n_cmp = 0, n_bad = 0;
    int seq = 0, bnum = 0, cur_grp = 0;
    int kcnt [4] = '{0, 0, 0, 0};
    logic [40:0] last_op [3];
    bit finished = 0, rnd_phase = 0;

    task automatic chk(bit ok, string req, string what, longint act, longint expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // pattern table from R3: kinds of slot0..2 (M=0 I=1 F=2 B=3), internal boundaries
    function automatic void pat_info(input int p, output int k0, output int k1,
                                     output int k2, output bit s0, output bit s1);
        s0 = 0; s1 = 0;
        case (p)
            0:  begin k0=0; k1=1; k2=1; end
            1:  begin k0=0; k1=1; k2=1; s1=1; end
            2:  begin k0=0; k1=0; k2=1; end
            3:  begin k0=0; k1=0; k2=1; s0=1; end
            4:  begin k0=0; k1=2; k2=1; end
            5:  begin k0=0; k1=0; k2=2; end
            6:  begin k0=0; k1=1; k2=3; end
            7:  begin k0=0; k1=3; k2=3; end
            8:  begin k0=3; k1=3; k2=3; end
            9:  begin k0=0; k1=0; k2=3; end
            default: begin k0=0; k1=2; k2=3; end
        endcase
    endfunction

    task automatic new_group();
        cur_grp++;
        for (int k = 0; k < 4; k++) kcnt[k] = 0;
    endtask

    // driver: computes expected routing, pushes it, then offers the bundle
    task automatic send(int pat, bit endstop);
        int kk [3];
        bit st [3];
        logic [127:0] b;
        bit legal;
        legal = (pat <= 10);
        pat_info(pat, kk[0], kk[1], kk[2], st[0], st[1]);
        st[2] = endstop;
        b = '0;
        b[4:0] = {4'(pat), endstop};
        for (int s = 0; s < 3; s++) begin
            last_op[s] = {9'h0, 8'(pat), 8'(bnum), 16'(seq)};
            seq++;
            b[5 + s*41 +: 41] = last_op[s];
            if (legal) begin
                item_t it;
                if (kcnt[kk[s]] == PPT) new_group();
                it.port = kk[s] * PPT + kcnt[kk[s]];
                it.op   = last_op[s];
                it.grp  = cur_grp;
                sb.push_back(it);
                kcnt[kk[s]]++;
                if (st[s]) new_group();
            end
        end
        bnum++;
        @(negedge clk);
        bnd_valid = 1'b1;
        bnd_data  = b;
        while (!bnd_ready) @(negedge clk);
        @(posedge clk);
        #1 bnd_valid = 1'b0;
    endtask

    task automatic set_rdy(logic [NP-1:0] v);
        @(posedge clk);
        #1 rdy = v;
    endtask

    task automatic drain();
        int guard = 0;
        while (sb.size() != 0 && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
    endtask

    // monitor: compares each consumed group against the scoreboard
    always @(negedge clk) begin : mon
        bit fire;
        int min_g, idx;
        int fired [$];
        if (!rst) begin
            fire = (pv != '0) && ((pv & ~rdy) == '0);
            if (fire) begin
                fired.delete();
                min_g = 32'h7fffffff;
                foreach (sb[i]) if (sb[i].grp < min_g) min_g = sb[i].grp;
                for (int q = 0; q < NP; q++) begin
                    if (pv[q]) begin
                        idx = -1;
                        foreach (sb[i]) if (idx < 0 && sb[i].op == pop[q]) idx = i;
                        chk(idx >= 0, "R2", "unexpected op payload", longint'(pop[q]), 0);
                        if (idx >= 0) begin
                            chk(sb[idx].port == q, "R2", "port of op", q, sb[idx].port);
                            chk(sb[idx].grp == min_g, "R5", "group order", sb[idx].grp, min_g);
                            fired.push_back(sb[idx].grp);
                            sb.delete(idx);
                        end
                    end
                end
                foreach (sb[i]) foreach (fired[j])
                    if (sb[i].grp == fired[j])
                        chk(0, "R6", "group split across cycles", sb[i].grp, -1);
            end
        end
    end

    initial begin : rnd_rdy
        forever begin
            @(posedge clk);
            #2;
            if (rnd_phase) rdy = NP'($urandom) | NP'($urandom);
        end
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            summary();
            $finish;
        end
    end

    initial begin : main
        void'($urandom(7));
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(pv == '0, "R1", "port valids after reset", longint'(pv), 0);
        chk(bnd_ready == 1'b1, "R1", "ready after reset", bnd_ready, 1);
        chk(bad == 1'b0, "R1", "bad flag after reset", bad, 0);

        // R2 R3 R5 R8: every legal pattern, ports free
        for (int p = 0; p <= 10; p++) send(p, 1'b1);
        drain();
        chk(sb.size() == 0, "R3", "all legal patterns issued", sb.size(), 0);

        // R4 illegal template
        send(13, 1'b1);
        @(negedge clk);
        chk(bad == 1'b1, "R4", "flag after illegal bundle", bad, 1);
        chk(pv == '0, "R4", "no issue from illegal bundle", longint'(pv), 0);
        @(negedge clk);
        chk(bad == 1'b0, "R4", "flag lasts one cycle", bad, 0);
        chk(pv == '0, "R4", "still no issue", longint'(pv), 0);

        // R7 stall on integer port 0
        set_rdy(NP'('1) & ~NP'(1 << (1*PPT)));
        send(0, 1'b1);
        repeat (3) @(negedge clk);
        chk(pv[1*PPT] == 1'b1, "R7", "stalled port keeps valid", pv[1*PPT], 1);
        chk(pop[1*PPT] == last_op[1], "R7", "stalled payload", longint'(pop[1*PPT]), longint'(last_op[1]));
        chk(pv[0] == 1'b1, "R7", "ready port held with group", pv[0], 1);
        chk(pop[0] == last_op[0], "R7", "held memory payload", longint'(pop[0]), longint'(last_op[0]));
        set_rdy('1);
        drain();

        // R6 R9 group spanning two bundles, window full
        set_rdy('0);
        send(0, 1'b0);
        send(10, 1'b1);
        @(negedge clk);
        chk(bnd_ready == 1'b0, "R9", "ready low with two bundles", bnd_ready, 0);
        chk($countones(pv) == 6, "R6", "spanning group width", $countones(pv), 6);
        set_rdy('1);
        @(negedge clk);
        @(negedge clk);
        chk(bnd_ready == 1'b1, "R9", "ready back after consumption", bnd_ready, 1);
        send(2, 1'b1);
        drain();

        // long stream with random port readiness (R2 R5 R7 R8 R9)
        rnd_phase = 1;
        for (int n = 0; n < 40; n++) send(int'($urandom_range(0, 10)), 1'b1);
        rnd_phase = 0;
        set_rdy('1);
        drain();
        chk(sb.size() == 0, "R9", "stream fully issued", sb.size(), 0);

        finished = 1;
        summary();
        $finish;
    end

endmodule